// File: doc/BRIEF.md
# Lock-Step Two-Way Stream Fork

This block takes one valid/ready stream whose word packs two fields and presents them as two separate valid/ready streams, branch A and branch B. Both halves of an upstream word leave together or not at all: the upstream word is accepted only in a cycle where both branches accept their halves. The producer cannot change one field of its word without changing the other, so delivering only one half would break the stream.

Each branch's valid is gated by the other branch's ready. A consumer therefore never sees a valid half that its partner could not take in the same cycle. The upstream ready is the AND of the two branch readies.

The block is purely combinational, and both field widths are parameters. Its valid outputs depend on ready inputs, so it needs registered handshakes around it, for example a FIFO on each branch. Without them, consumers whose ready depends on valid form combinational loops. Nested groupings of channels are handled by cascading several forks.

Top module: `lockstep_fork`

## Requirements
- R1: `up_ready` is high exactly when both `a_ready` and `b_ready` are high.
- R2: `a_valid` is high exactly when `up_valid` and `b_ready` are both high.
- R3: `b_valid` is high exactly when `up_valid` and `a_ready` are both high.
- R4: In every cycle, a transfer on A (`a_valid` and `a_ready`), a transfer on B, and an upstream transfer (`up_valid` and `up_ready`) are either all present or all absent.
- R5: `a_data` carries the upper `A_W` bits of `up_data`, and `b_data` carries the lower `B_W` bits.
- R6: With `up_valid` low, both `a_valid` and `b_valid` stay low whatever the ready inputs are.
- R7: The data outputs follow `up_data` whatever the handshake state is, including when `up_valid` is low.
- R8: Under arbitrary valid and ready patterns, the running count of A transfers and the running count of B transfers each equal the running count of upstream transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| up_valid | input | 1 | Upstream word is valid |
| up_data | input | A_W+B_W | Upstream word; A field in the upper bits |
| up_ready | output | 1 | Both branches can accept this cycle |
| a_valid | output | 1 | Branch A half is offered |
| a_data | output | A_W | Branch A field |
| a_ready | input | 1 | Branch A consumer accepts |
| b_valid | output | 1 | Branch B half is offered |
| b_data | output | B_W | Branch B field |
| b_ready | input | 1 | Branch B consumer accepts |

## Verification
The checker tests a set of relations on every input change:
- a branch valid implies the upstream valid and the other branch's ready;
- the three transfers coincide;
- a low upstream valid silences both branches;
- the two output fields reassemble the upstream word.

The exact truth tables for the readies, the field slicing for specific patterns, and the equality of the three cumulative transfer counts under a long pseudo-random stretch of valid and backpressure are shown only by the bench scenarios.

// File: rtl/lockstep_fork_pkg.sv
package lockstep_fork_pkg;

  // One handshake channel: forward valid, backward ready.
  typedef struct packed {
    logic valid;
    logic ready;
  } hs_t;

  localparam int unsigned BRANCHES = 2;

endpackage

// File: rtl/lockstep_fork_split.sv
module lockstep_fork_split #(
  parameter int unsigned A_W = 8,
  parameter int unsigned B_W = 12
) (
  input  logic [A_W+B_W-1:0] word_i,
  output logic [A_W-1:0]     hi_o,
  output logic [B_W-1:0]     lo_o
);
  localparam int unsigned W = A_W + B_W;

  // Upper field to branch A, lower field to branch B.
  assign hi_o = word_i[W-1:B_W];
  assign lo_o = word_i[B_W-1:0];
endmodule

// File: rtl/lockstep_fork_hs.sv
module lockstep_fork_hs
  import lockstep_fork_pkg::*;
#(
  parameter int unsigned N = BRANCHES
) (
  input  logic         src_valid,
  output logic         src_ready,
  input  logic [N-1:0] br_ready,
  output logic [N-1:0] br_valid
);
  // Each branch is offered data only when every other branch can take
  // its half in the same cycle.
  for (genvar g = 0; g < N; g++) begin : g_br
    logic [N-1:0] others;
    always_comb begin
      others    = br_ready;
      others[g] = 1'b1;
    end
    assign br_valid[g] = src_valid & (&others);
  end

  assign src_ready = &br_ready;
endmodule

// File: rtl/lockstep_fork.sv
module lockstep_fork
  import lockstep_fork_pkg::*;
#(
  parameter int unsigned A_W = 8,
  parameter int unsigned B_W = 12
) (
  input  logic               up_valid,
  input  logic [A_W+B_W-1:0] up_data,
  output logic               up_ready,
  output logic               a_valid,
  output logic [A_W-1:0]     a_data,
  input  logic               a_ready,
  output logic               b_valid,
  output logic [B_W-1:0]     b_data,
  input  logic               b_ready
);
  hs_t chan_a, chan_b;
  logic [BRANCHES-1:0] rdy_vec, vld_vec;

  assign chan_a.ready = a_ready;
  assign chan_b.ready = b_ready;
  assign rdy_vec      = {chan_b.ready, chan_a.ready};

  lockstep_fork_hs #(.N(BRANCHES)) u_hs (
    .src_valid (up_valid),
    .src_ready (up_ready),
    .br_ready  (rdy_vec),
    .br_valid  (vld_vec)
  );

  assign chan_a.valid = vld_vec[0];
  assign chan_b.valid = vld_vec[1];
  assign a_valid      = chan_a.valid;
  assign b_valid      = chan_b.valid;

  lockstep_fork_split #(.A_W(A_W), .B_W(B_W)) u_split (
    .word_i (up_data),
    .hi_o   (a_data),
    .lo_o   (b_data)
  );
endmodule

// File: rtl/lockstep_fork_chk.sv
module lockstep_fork_chk #(
  parameter int unsigned A_W = 8,
  parameter int unsigned B_W = 12
) (
  input logic               up_valid,
  input logic [A_W+B_W-1:0] up_data,
  input logic               up_ready,
  input logic               a_valid,
  input logic [A_W-1:0]     a_data,
  input logic               a_ready,
  input logic               b_valid,
  input logic [B_W-1:0]     b_data,
  input logic               b_ready
);
  always_comb begin
    AST_UP_READY_NEEDS_BOTH: assert (!up_ready || (a_ready && b_ready)) else $error("up_ready without both readies"); // R1
    AST_A_VALID_GATED: assert (!a_valid || (up_valid && b_ready)) else $error("a_valid without up_valid and b_ready"); // R2
    AST_B_VALID_GATED: assert (!b_valid || (up_valid && a_ready)) else $error("b_valid without up_valid and a_ready"); // R3
    AST_XFER_AB_TOGETHER: assert ((a_valid && a_ready) == (b_valid && b_ready)) else $error("branch transfers split"); // R4
    AST_XFER_UP_TOGETHER: assert ((a_valid && a_ready) == (up_valid && up_ready)) else $error("upstream transfer mismatch"); // R4
    AST_FIELDS_REASSEMBLE: assert ({a_data, b_data} == up_data) else $error("fields do not rebuild word"); // R5
    AST_IDLE_SILENT: assert (up_valid || (!a_valid && !b_valid)) else $error("branch valid while upstream idle"); // R6
  end
endmodule

bind lockstep_fork lockstep_fork_chk #(.A_W(A_W), .B_W(B_W)) u_chk (.*);

// File: tb/lockstep_fork_tb.sv
`timescale 1ns/1ps
module lockstep_fork_tb;
  localparam int unsigned A_W = 8;
  localparam int unsigned B_W = 12;
  localparam int unsigned W   = A_W + B_W;

  logic clk = 1'b0;
  logic rst;
  always #2 clk = ~clk;

  logic         up_valid, up_ready, a_valid, a_ready, b_valid, b_ready;
  logic [W-1:0] up_data;
  logic [A_W-1:0] a_data;
  logic [B_W-1:0] b_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  lockstep_fork #(.A_W(A_W), .B_W(B_W)) u_dut (
    .up_valid(up_valid), .up_data(up_data), .up_ready(up_ready),
    .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
    .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Apply inputs just after a rising edge, then sample at the falling edge.
  task automatic drive(input bit v, input logic [W-1:0] d, input bit ra, input bit rb);
    @(posedge clk); #0.5;
    up_valid = v; up_data = d; a_ready = ra; b_ready = rb;
    @(negedge clk);
  endtask

  task automatic t_reset_idle();
    rst = 1'b1;
    drive(1'b0, '0, 1'b0, 1'b0);
    chk(!a_valid && !b_valid && !up_ready, "R6 idle outputs", {a_valid, b_valid, up_ready}, 0);
    rst = 1'b0;
  endtask

  task automatic t_ready_table();
    for (int v = 0; v < 2; v++) begin
      for (int c = 0; c < 4; c++) begin
        bit ra, rb;
        ra = c[0]; rb = c[1];
        drive(v[0], W'(20'h5A5A5), ra, rb);
        chk(up_ready == (ra & rb), "R1 up_ready", up_ready, ra & rb);
        chk(a_valid == (v[0] & rb), "R2 a_valid", a_valid, v[0] & rb);
        chk(b_valid == (v[0] & ra), "R3 b_valid", b_valid, v[0] & ra);
        if (!v[0]) chk(!a_valid && !b_valid, "R6 silent when idle", {a_valid, b_valid}, 0);
        chk(((a_valid & a_ready) == (b_valid & b_ready)) && ((a_valid & a_ready) == (up_valid & up_ready)),
            "R4 joint transfer", {a_valid & a_ready, b_valid & b_ready, up_valid & up_ready}, 0);
      end
    end
  endtask

  task automatic t_fields();
    logic [W-1:0] pats [5];
    pats[0] = 20'h00000; pats[1] = 20'hFFFFF; pats[2] = 20'hAB123;
    pats[3] = 20'h80001; pats[4] = 20'h01800;
    foreach (pats[i]) begin
      drive(1'b1, pats[i], 1'b1, 1'b1);
      chk(a_data == pats[i][W-1:B_W], "R5 A field", a_data, pats[i][W-1:B_W]);
      chk(b_data == pats[i][B_W-1:0], "R5 B field", b_data, pats[i][B_W-1:0]);
    end
    drive(1'b0, 20'h3C7E1, 1'b0, 1'b1);
    chk({a_data, b_data} == 20'h3C7E1, "R7 data while idle", {a_data, b_data}, 20'h3C7E1);
  endtask

  task automatic t_random_backpressure();
    logic [15:0] lfsr = 16'hACE1;
    int cu = 0, ca = 0, cb = 0;
    bit ok = 1'b1;
    for (int i = 0; i < 800; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0], W'({lfsr, lfsr[3:0]}), lfsr[5] | lfsr[1], lfsr[7] | lfsr[2]);
      if (up_valid && up_ready) cu++;
      if (a_valid && a_ready) ca++;
      if (b_valid && b_ready) cb++;
      if (ca != cu || cb != cu) ok = 1'b0;
    end
    chk(ok && ca == cu, "R8 A count equals upstream", ca, cu);
    chk(ok && cb == cu, "R8 B count equals upstream", cb, cu);
    chk(cu > 0, "R8 some transfers occurred", cu, 1);
  endtask

  initial begin
    up_valid = 1'b0; up_data = '0; a_ready = 1'b0; b_ready = 1'b0; rst = 1'b1;
    t_reset_idle();
    t_ready_table();
    t_fields();
    t_random_backpressure();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule